// File: doc/BRIEF.md
# Level-Sensitive Interrupt Bank with Three Request Lines

This block gathers 32 level-sensitive interrupt inputs into a single bank and drives three processor request lines: a normal request, a fast request and an endpoint request. Each input is brought into the clock domain through a two-flop synchroniser. The synchronised word is the cause word. It is shown to software without any masking, so it follows the inputs: a bit stays set while its source is high and clears only when the source goes low.

Each request line has its own 32-bit enable register. A line asserts, one clock after the change that causes it, whenever any cause bit is set together with the matching bit of that line's enable register. Software reads the cause word and ANDs it with the enable register to find the pending sources. There is no priority encoder. A larger controller is built by instantiating several banks.

The register bank uses a simple bus: a byte address, a write strobe, 32-bit write data and combinational read data. The cause word is at offset 0x00 and is read-only. The normal, fast and endpoint enable registers are at 0x04, 0x08 and 0x0C.

Top module: `lvl_irq_bank`

## Requirements
- R1: After reset, all three enable registers read zero and all three request outputs are low.
- R2: A read of offset 0x00 returns the synchronised input word unmasked, with bit n equal to src_i[n]. A change on src_i appears in the read value two clock edges after it is applied.
- R3: A cause bit stays set for as long as its source is held high, and it clears only when that source goes low. A write to offset 0x00 changes neither the cause word nor any request output.
- R4: Writes to offsets 0x04, 0x08 and 0x0C load the normal, fast and endpoint enable registers, and reads of those offsets return the stored values. A bit value of 1 enables the source and 0 blocks it.
- R5: irq_o is high exactly when (cause AND normal enable) is non-zero, registered, so it changes one clock after the cause word or the enable register changes.
- R6: fiq_o follows the same rule as R5, using the fast enable register at 0x08.
- R7: endp_o follows the same rule as R5, using the endpoint enable register at 0x0C.
- R8: A write to one enable register leaves the other two unchanged.
- R9: An offset other than 0x00, 0x04, 0x08 or 0x0C, including an offset that is not a multiple of four, reads zero, and a write to it changes no register.
- R10: When an enable register holds zero, its request output stays low whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously and is released synchronously inside the block |
| src_i | input | 32 | Level-sensitive interrupt sources, bit n for source n |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| endp_o | output | 1 | Endpoint interrupt request |

## Verification
The assertions check on every cycle that each request line equals the OR of the previous cycle's cause word ANDed with that line's enable register. They also check that an enable register changes only when its own offset is written, that unmapped offsets read zero, and that a zero enable register keeps its line low. The bench scenarios cover what those per-cycle relations cannot show: the two-edge latency from an input to the cause word and that the cause word carries no masking. They also show that a held source keeps its bit set, that writes to the cause offset and to unmapped offsets leave the block unchanged, and how a mixed pattern of sources and enables sets each line.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int NUM_SRC     = 32;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int NUM_REQ     = 3;
  localparam int SYNC_STAGES = 2;
  localparam int BYTES_PER_W = DATA_W / 8;

  typedef enum logic [1:0] {
    REQ_NORMAL = 2'd0,
    REQ_FAST   = 2'd1,
    REQ_ENDP   = 2'd2
  } req_sel_e;

  localparam logic [ADDR_W-1:0] OFS_CAUSE = '0;
endpackage

// File: rtl/lvl_irq_rst_sync.sv
module lvl_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] flop_q;
    logic [STAGES-1:0] flop_d;

    always_comb begin
      flop_d = {flop_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flop_q <= '0;
      else        flop_q <= flop_d;
    end

    assign sync_o[b] = flop_q[STAGES-1];
  end
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W,
  parameter int NR  = NUM_REQ,
  parameter int BPW = BYTES_PER_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         cause_i,
  input  logic [AW-1:0]         addr_i,
  input  logic                  we_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  output logic [NR-1:0][DW-1:0] mask_o
);
  logic [NR-1:0][DW-1:0] mask_q;
  logic [NR-1:0][DW-1:0] mask_d;
  logic [NR-1:0]         hit;
  logic [NR-1:0]         load_en;
  logic                  hit_cause;

  always_comb begin
    hit_cause = (addr_i == OFS_CAUSE);
    for (int k = 0; k < NR; k++) begin
      hit[k] = (addr_i == AW'((k + 1) * BPW));
    end
  end

  always_comb begin
    load_en = hit & {NR{we_i}};
    for (int k = 0; k < NR; k++) begin
      mask_d[k] = load_en[k] ? wdata_i : mask_q[k];
    end
  end

  for (genvar k = 0; k < NR; k++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q[k] <= '0;
      else if (load_en[k]) mask_q[k] <= mask_d[k];
    end
  end

  always_comb begin
    rdata_o = hit_cause ? cause_i : '0;
    for (int k = 0; k < NR; k++) begin
      if (hit[k]) rdata_o = mask_q[k];
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/lvl_irq_req.sv
module lvl_irq_req #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cause_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             req_o
);
  logic req_d;
  logic req_q;

  always_comb begin
    req_d = |(cause_i & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank
  import lvl_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              endp_o
);
  logic                          rst_q;
  logic [DATA_W-1:0]             cause_w;
  logic [NUM_REQ-1:0][DATA_W-1:0] mask_w;
  logic [NUM_REQ-1:0]            req_w;

  lvl_irq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  lvl_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_q),
    .async_i (src_i),
    .sync_o  (cause_w)
  );

  lvl_irq_regs i_regs (
    .clk     (clk),
    .rst_n   (rst_q),
    .cause_i (cause_w),
    .addr_i  (bus_addr),
    .we_i    (bus_we),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .mask_o  (mask_w)
  );

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_req
    lvl_irq_req #(.WIDTH(DATA_W)) i_req (
      .clk     (clk),
      .rst_n   (rst_q),
      .cause_i (cause_w),
      .mask_i  (mask_w[k]),
      .req_o   (req_w[k])
    );
  end

  assign irq_o  = req_w[REQ_NORMAL];
  assign fiq_o  = req_w[REQ_FAST];
  assign endp_o = req_w[REQ_ENDP];
endmodule

// File: rtl/lvl_irq_bank_chk.sv
module lvl_irq_bank_chk
  import lvl_irq_pkg::*;
(
  input logic                           clk,
  input logic                           rst_q,
  input logic [DATA_W-1:0]              cause,
  input logic [NUM_REQ-1:0][DATA_W-1:0] mask,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic                           bus_we,
  input logic [DATA_W-1:0]              bus_rdata,
  input logic                           irq_o,
  input logic                           fiq_o,
  input logic                           endp_o
);
  logic mapped;
  assign mapped = (bus_addr == 8'h00) || (bus_addr == 8'h04) ||
                  (bus_addr == 8'h08) || (bus_addr == 8'h0C);

  p_irq_match_r5: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (irq_o == |($past(cause) & $past(mask[0]))));

  p_fiq_match_r6: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (fiq_o == |($past(cause) & $past(mask[1]))));

  p_endp_match_r7: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (endp_o == |($past(cause) & $past(mask[2]))));

  p_hold_normal_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_we && bus_addr == 8'h04) |=> $stable(mask[0]));

  p_hold_fast_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_we && bus_addr == 8'h08) |=> $stable(mask[1]));

  p_hold_endp_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_we && bus_addr == 8'h0C) |=> $stable(mask[2]));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_q)
    !mapped |-> (bus_rdata == '0));

  p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (mask[0] == '0) |=> !irq_o);
endmodule

bind lvl_irq_bank lvl_irq_bank_chk i_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .cause     (cause_w),
  .mask      (mask_w),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .endp_o    (endp_o)
);

// File: tb/test_lvl_irq_bank.sv
`timescale 1ns/1ps
module test_lvl_irq_bank;
  logic        clk;
  logic        rst_n;
  logic [31:0] src_i;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, endp_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  lvl_irq_bank i_lvl_irq_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .endp_o(endp_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic chk_out(input string req, input logic [2:0] exp);
    check(req, {29'd0, irq_o, fiq_o, endp_o}, {29'd0, exp});
  endtask

  task automatic t_reset;
    chk_reg("R1 normal mask", 8'h04, 32'h0);
    chk_reg("R1 fast mask",   8'h08, 32'h0);
    chk_reg("R1 endp mask",   8'h0C, 32'h0);
    chk_out("R1 outputs", 3'b000);
  endtask

  task automatic t_cause_latency;
    src_i = 32'hA5A5_0F0F;
    clks(1);
    chk_reg("R2 cause one edge", 8'h00, 32'h0);
    clks(1);
    chk_reg("R2 cause two edges", 8'h00, 32'hA5A5_0F0F);
    chk_out("R10 masks zero", 3'b000);
  endtask

  task automatic t_masks;
    wr(8'h04, 32'h0000_0001);
    wr(8'h08, 32'h8000_0000);
    wr(8'h0C, 32'h0F00_0000);
    chk_reg("R4 normal readback", 8'h04, 32'h0000_0001);
    chk_reg("R4 fast readback",   8'h08, 32'h8000_0000);
    chk_reg("R8 endp kept",       8'h0C, 32'h0F00_0000);
    wr(8'h08, 32'h0000_0100);
    chk_reg("R8 normal untouched", 8'h04, 32'h0000_0001);
    chk_reg("R8 endp untouched",   8'h0C, 32'h0F00_0000);
  endtask

  task automatic t_outputs;
    src_i = 32'h0;
    clks(4);
    chk_out("R5 R6 R7 idle", 3'b000);
    src_i = 32'h0000_0001;
    clks(2);
    chk_out("R5 before output reg", 3'b000);
    clks(1);
    chk_out("R5 normal only", 3'b100);
    src_i = 32'h0000_0100;
    clks(4);
    chk_out("R6 fast only", 3'b010);
    src_i = 32'h0200_0000;
    clks(4);
    chk_out("R7 endp only", 3'b001);
    src_i = 32'h0200_0101;
    clks(4);
    chk_out("R5 R6 R7 all", 3'b111);
    chk_reg("R2 unmasked cause", 8'h00, 32'h0200_0101);
    wr(8'h0C, 32'h0);
    chk_out("R7 mask clear lag", 3'b111);
    clks(1);
    chk_out("R10 endp blocked", 3'b110);
    wr(8'h0C, 32'h0F00_0000);
    clks(1);
  endtask

  task automatic t_level_hold;
    src_i = 32'h0000_0001;
    clks(4);
    wr(8'h00, 32'h0);
    clks(8);
    chk_reg("R3 held bit stays", 8'h00, 32'h0000_0001);
    chk_out("R3 output stays", 3'b100);
    src_i = 32'h0;
    clks(4);
    chk_reg("R3 clears on release", 8'h00, 32'h0);
    chk_out("R3 output drops", 3'b000);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    clks(2);
    chk_reg("R3 cause write ignored", 8'h00, 32'h0);
    chk_out("R3 no request", 3'b000);
  endtask

  task automatic t_unmapped;
    chk_reg("R9 read 0x10", 8'h10, 32'h0);
    chk_reg("R9 read 0x05", 8'h05, 32'h0);
    chk_reg("R9 read 0xFC", 8'hFC, 32'h0);
    wr(8'h10, 32'h1234_5678);
    wr(8'h06, 32'h0);
    chk_reg("R9 normal kept", 8'h04, 32'hFFFF_FFFF);
    chk_reg("R9 fast kept",   8'h08, 32'h0000_0100);
    chk_reg("R9 endp kept",   8'h0C, 32'h0F00_0000);
  endtask

  task automatic t_zero_mask;
    wr(8'h04, 32'h0);
    src_i = 32'hFFFF_FFFF;
    clks(4);
    chk_out("R10 normal zero mask", 3'b011);
    src_i = 32'h0;
    clks(4);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; src_i = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    #1 rst_n = 1'b0;
    clks(3);
    rst_n = 1'b1;
    clks(4);
    t_reset();
    t_cause_latency();
    t_masks();
    t_outputs();
    t_level_hold();
    t_unmapped();
    t_zero_mask();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule